// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB panel. Two counters track the position in the frame: one counts pixels across a line and one counts lines. Comparators derive the horizontal and vertical sync pulses, the data-enable window and a pixel request from those counts. Every timing value comes from configuration inputs. These inputs give the sync widths, the line and frame totals, and the first and one-past-last active positions on each axis. Per-signal polarity bits set the active level of each sync and data-enable output.

The configuration is copied into shadow registers only at a frame boundary, or on any cycle while the block is stopped. Software can therefore rewrite the inputs at any time without tearing a frame. A run input starts the raster at once from position zero. Dropping the run input lets the current frame finish before the counters park at zero and the outputs go to their inactive levels. The pixel request has a fixed sense and feeds the pixel fetch logic. The pixel-clock edge select and the 18-bit panel-width select pass through the shadow so that the pixel path can use them.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset and while stopped, hcount and vcount are 0, pix_req is 0, and hsync, vsync and de sit at their inactive level. The inactive level is 1 when the matching low-active bit is set and 0 when it is clear.
- R2: While running, hcount steps by one each cycle and returns to 0 after the value H total minus 1 (timing_total bits 31:16). vcount steps by one at each such return and goes back to 0 after V total minus 1 (timing_total bits 15:0).
- R3: The true-sense horizontal sync is asserted while hcount < hsync_len, and the vertical sync while vcount < vsync_len. A width of 0 gives no pulse.
- R4: de and pix_req are asserted only when hcount lies in [timing_hact[31:16], timing_hact[15:0]) and vcount lies in [timing_vact[31:16], timing_vact[15:0]).
- R5: hs_low, vs_low and de_low each invert only their own output. pix_req is never inverted.
- R6: A change to any configuration input during a frame has no effect until the first cycle of the next frame (hcount = vcount = 0).
- R7: When run is sampled high in the stopped state, the next cycle starts a frame at hcount = vcount = 0.
- R8: When run is sampled low during a frame, counting continues to the end of that frame, and then the block enters the stopped state.
- R9: pclk_fall and bus18 present the clk_fall and wide18 inputs through the same frame-boundary shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start raster / stop at end of frame |
| timing_total | input | 32 | H total [31:16], V total [15:0] |
| timing_hact | input | 32 | Horizontal active start [31:16], end [15:0] |
| timing_vact | input | 32 | Vertical active start [31:16], end [15:0] |
| hsync_len | input | 16 | Horizontal sync width in pixels |
| vsync_len | input | 16 | Vertical sync width in lines |
| hs_low | input | 1 | Horizontal sync active low |
| vs_low | input | 1 | Vertical sync active low |
| de_low | input | 1 | Data enable active low |
| clk_fall | input | 1 | Launch pixel data on falling clock edge |
| wide18 | input | 1 | 18-bit panel data instead of 16-bit |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Pixel request, active high |
| hcount | output | 16 | Pixel position within line |
| vcount | output | 16 | Line position within frame |
| pclk_fall | output | 1 | Shadowed clock-edge select |
| bus18 | output | 1 | Shadowed panel-width select |

## Verification
Every output is a combinational decode of the counters and shadow registers. So an input sampled at a rising edge shows its effect right after that edge: a start request, a stop at frame end, and a new configuration at the frame wrap. A reference process works out the expected outputs at each rising edge and queues them. A monitor pops each entry at the following falling edge, which is exactly one register stage later. Directed checks read the outputs 1 ns after a rising edge, at chosen raster positions. These cover sync width, window edges, the deferred configuration change and the end-of-frame stop.

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int CW = 16,
  localparam int RW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] timing_total,
  input  logic [RW-1:0] timing_hact,
  input  logic [RW-1:0] timing_vact,
  input  logic [CW-1:0] hsync_len,
  input  logic [CW-1:0] vsync_len,
  input  logic          hs_low,
  input  logic          vs_low,
  input  logic          de_low,
  input  logic          clk_fall,
  input  logic          wide18,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_req,
  output logic [CW-1:0] hcount,
  output logic [CW-1:0] vcount,
  output logic          pclk_fall,
  output logic          bus18
);

  logic          on;
  logic [CW-1:0] hc, vc;
  logic [CW-1:0] ht_sh, vt_sh, hds_sh, hde_sh, vds_sh, vde_sh, hsw_sh, vsw_sh;
  logic          hsl_sh, vsl_sh, del_sh, cf_sh, w18_sh;

  wire h_last  = (hc == ht_sh - CW'(1));
  wire v_last  = (vc == vt_sh - CW'(1));
  wire f_last  = on && h_last && v_last;
  wire load    = !on || f_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ht_sh  <= '0; vt_sh  <= '0;
      hds_sh <= '0; hde_sh <= '0;
      vds_sh <= '0; vde_sh <= '0;
      hsw_sh <= '0; vsw_sh <= '0;
      hsl_sh <= 1'b0; vsl_sh <= 1'b0; del_sh <= 1'b0;
      cf_sh  <= 1'b0; w18_sh <= 1'b0;
    end else if (load) begin
      ht_sh  <= timing_total[RW-1:CW];
      vt_sh  <= timing_total[CW-1:0];
      hds_sh <= timing_hact[RW-1:CW];
      hde_sh <= timing_hact[CW-1:0];
      vds_sh <= timing_vact[RW-1:CW];
      vde_sh <= timing_vact[CW-1:0];
      hsw_sh <= hsync_len;
      vsw_sh <= vsync_len;
      hsl_sh <= hs_low;
      vsl_sh <= vs_low;
      del_sh <= de_low;
      cf_sh  <= clk_fall;
      w18_sh <= wide18;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on <= 1'b0;
      hc <= '0;
      vc <= '0;
    end else if (!on) begin
      on <= run;
      hc <= '0;
      vc <= '0;
    end else if (h_last) begin
      hc <= '0;
      if (v_last) begin
        vc <= '0;
        on <= run;
      end else begin
        vc <= vc + CW'(1);
      end
    end else begin
      hc <= hc + CW'(1);
    end
  end

  wire hs_act = on && (hc < hsw_sh);
  wire vs_act = on && (vc < vsw_sh);
  wire in_h   = (hc >= hds_sh) && (hc < hde_sh);
  wire in_v   = (vc >= vds_sh) && (vc < vde_sh);
  wire de_act = on && in_h && in_v;

  assign hsync     = hs_act ^ hsl_sh;
  assign vsync     = vs_act ^ vsl_sh;
  assign de        = de_act ^ del_sh;
  assign pix_req   = de_act;
  assign hcount    = hc;
  assign vcount    = vc;
  assign pclk_fall = cf_sh;
  assign bus18     = w18_sh;

endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          on,
  input logic          pix_req,
  input logic [CW-1:0] hcount,
  input logic [CW-1:0] vcount,
  input logic [CW-1:0] ht_sh,
  input logic [CW-1:0] vt_sh
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> (hcount == '0 && vcount == '0 && !pix_req)); // R1

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (on && $past(on) && hcount != '0) |-> hcount == $past(hcount) + CW'(1)); // R2

  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hcount != '0 |-> $stable(vcount)); // R2

  AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (on && ht_sh != '0) |-> hcount < ht_sh); // R2

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(on) && on && !(hcount == '0 && vcount == '0)) |-> ($stable(ht_sh) && $stable(vt_sh))); // R6

  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on) |-> ($past(hcount) == $past(ht_sh) - CW'(1) && $past(vcount) == $past(vt_sh) - CW'(1))); // R8

endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .on(on), .pix_req(pix_req),
  .hcount(hcount), .vcount(vcount), .ht_sh(ht_sh), .vt_sh(vt_sh)
);

// File: tb/lcd_sync_gen_test.sv
`timescale 1ns/1ps
module lcd_sync_gen_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [31:0] timing_total = '0, timing_hact = '0, timing_vact = '0;
  logic [CW-1:0] hsync_len = '0, vsync_len = '0;
  logic hs_low = 0, vs_low = 0, de_low = 0, clk_fall = 0, wide18 = 0;
  logic hsync, vsync, de, pix_req, pclk_fall, bus18;
  logic [CW-1:0] hcount, vcount;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lcd_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .timing_total(timing_total), .timing_hact(timing_hact), .timing_vact(timing_vact),
    .hsync_len(hsync_len), .vsync_len(vsync_len),
    .hs_low(hs_low), .vs_low(vs_low), .de_low(de_low),
    .clk_fall(clk_fall), .wide18(wide18),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
    .hcount(hcount), .vcount(vcount), .pclk_fall(pclk_fall), .bus18(bus18)
  );

  // reference: {hsync,vsync,de,pix_req,pclk_fall,bus18,hcount,vcount}
  logic [37:0] exp_q[$];
  logic m_on = 0;
  logic [15:0] m_h = 0, m_v = 0;
  logic [15:0] s_ht = 0, s_vt = 0, s_hds = 0, s_hde = 0, s_vds = 0, s_vde = 0, s_hsw = 0, s_vsw = 0;
  logic s_hsl = 0, s_vsl = 0, s_del = 0, s_cf = 0, s_w18 = 0;

  always @(posedge clk) begin
    logic ld, hs, vs, da;
    if (!rst_n) begin
      m_on = 0; m_h = 0; m_v = 0;
      {s_ht, s_vt, s_hds, s_hde, s_vds, s_vde, s_hsw, s_vsw} = '0;
      {s_hsl, s_vsl, s_del, s_cf, s_w18} = '0;
    end else begin
      ld = !m_on || (m_h == s_ht - 16'd1 && m_v == s_vt - 16'd1);
      if (!m_on) begin
        m_on = run;
      end else if (m_h == s_ht - 16'd1) begin
        m_h = 0;
        if (m_v == s_vt - 16'd1) begin m_v = 0; m_on = run; end
        else m_v = m_v + 16'd1;
      end else m_h = m_h + 16'd1;
      if (ld) begin
        s_ht = timing_total[31:16]; s_vt = timing_total[15:0];
        s_hds = timing_hact[31:16]; s_hde = timing_hact[15:0];
        s_vds = timing_vact[31:16]; s_vde = timing_vact[15:0];
        s_hsw = hsync_len; s_vsw = vsync_len;
        s_hsl = hs_low; s_vsl = vs_low; s_del = de_low; s_cf = clk_fall; s_w18 = wide18;
      end
    end
    hs = m_on && m_h < s_hsw;
    vs = m_on && m_v < s_vsw;
    da = m_on && m_h >= s_hds && m_h < s_hde && m_v >= s_vds && m_v < s_vde;
    exp_q.push_back({hs ^ s_hsl, vs ^ s_vsl, da ^ s_del, da, s_cf, s_w18, m_h, m_v});
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [37:0] e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk("R3/R5 hsync", 32'(hsync), 32'(e[37]));
      chk("R3/R5 vsync", 32'(vsync), 32'(e[36]));
      chk("R4/R5 de", 32'(de), 32'(e[35]));
      chk("R4 pix_req", 32'(pix_req), 32'(e[34]));
      chk("R9 pclk_fall", 32'(pclk_fall), 32'(e[33]));
      chk("R9 bus18", 32'(bus18), 32'(e[32]));
      chk("R2 hcount", 32'(hcount), 32'(e[31:16]));
      chk("R2 vcount", 32'(vcount), 32'(e[15:0]));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic goto(int h, int v);
    for (int i = 0; i < 400; i++) begin
      if (hcount == 16'(h) && vcount == 16'(v)) return;
      step();
    end
  endtask

  task automatic tests();
    repeat (3) step();
    chk("R1 reset hcount", 32'(hcount), 0);
    chk("R1 reset outputs", {hsync, vsync, de, pix_req}, 0);
    rst_n = 1'b1;
    timing_total = 32'h000A_0006; timing_hact = 32'h0003_0008; timing_vact = 32'h0002_0005;
    hsync_len = 16'd2; vsync_len = 16'd1;
    step();
    run = 1'b1;
    step();
    chk("R7 start hcount", 32'(hcount), 0);
    chk("R7 start vcount", 32'(vcount), 0);
    chk("R3 hsync at 0", 32'(hsync), 1);
    chk("R3 vsync line 0", 32'(vsync), 1);
    step();
    chk("R7 counting", 32'(hcount), 1);
    goto(2, 0);
    chk("R3 hsync end", 32'(hsync), 0);
    goto(9, 1);
    hsync_len = 16'd4;
    goto(2, 2);
    chk("R6 old width kept", 32'(hsync), 0);
    goto(3, 2);
    chk("R4 de start", {de, pix_req}, 2'b11);
    goto(8, 2);
    chk("R4 de end", {de, pix_req}, 0);
    goto(2, 0);
    chk("R6 new width used", 32'(hsync), 1);
    goto(3, 1);
    chk("R4 de outside v window", 32'(de), 0);
    goto(5, 3);
    run = 1'b0;
    step();
    chk("R8 keeps counting", 32'(hcount), 6);
    goto(9, 5);
    step();
    step();
    chk("R8 parked hcount", 32'(hcount), 0);
    chk("R1 idle outputs", {hsync, vsync, de, pix_req}, 0);
    timing_total = 32'h0007_0004; timing_hact = 32'h0001_0006; timing_vact = 32'h0000_0003;
    hsync_len = 16'd0; vsync_len = 16'd2;
    hs_low = 1; vs_low = 1; de_low = 1; clk_fall = 1; wide18 = 1;
    step();
    chk("R5 idle inverted", {hsync, vsync, de, pix_req}, 4'b1110);
    run = 1'b1;
    step();
    goto(1, 0);
    chk("R5 de low active", {de, pix_req}, 2'b01);
    chk("R5 vsync low active", 32'(vsync), 0);
    chk("R3 zero width no pulse", 32'(hsync), 1);
    chk("R9 shadowed selects", {pclk_fall, bus18}, 2'b11);
    goto(6, 3);
    step();
    goto(6, 3);
    step();
    step();
  endtask

  initial begin
    fork
      tests();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule